// File: doc/BRIEF.md
# Lockstep Stream Fan-Out

This block copies one inbound valid/ready stream onto several outbound streams. It has no storage, so a beat leaves on all outputs in the same cycle or on none of them. The inbound side is ready only when every outbound consumer is ready. Each outbound valid is qualified by the readiness of all the other outputs. A consumer that is ready therefore never completes a handshake while one of its siblings is stalled.

The outbound signals are packed into flat buses with one slice per port, and port 0 sits in the least significant slice. Each port takes its own contiguous window of the inbound data and user bits. The window is given by a per-port low-bit parameter and a common output width, so an output can be narrower than the input. The end-of-packet flag is copied into every port's slice. With a single port the block reduces to a pass-through.

Top module: `stream_fanout`

## Requirements
- R1: `s_ready` is high exactly when every bit of `m_ready` is high.
- R2: `m_valid[i]` is high exactly when `s_valid` is high and every `m_ready` bit other than bit i is high. The port's own ready bit plays no part.
- R3: A handshake on any output port (`m_valid[i]` and `m_ready[i]` both high) happens only in a cycle where the inbound transfer (`s_valid` and `s_ready`) also happens.
- R4: The outbound buses are packed with port i in bits `[i*W +: W]`, where W is the per-port width of the bus.
- R5: The data slice of port i equals `s_data[DLSB_i +: OUT_DATA_W]`, where DLSB_i is the 8-bit field i of `DATA_LSB_PACK`. With the defaults the low bits are 0, 8 and 4 for ports 0, 1 and 2. A window that does not fit inside the inbound width is rejected at elaboration.
- R6: The user slice of port i equals `s_user[ULSB_i +: OUT_USER_W]`, where ULSB_i is the 8-bit field i of `USER_LSB_PACK`. With the defaults the low bits are 0, 4 and 2.
- R7: `m_last[i]` equals `s_last` for every port i, not only for port 0.
- R8: With `NUM_PORTS` = 1, `m_valid` equals `s_valid` and `s_ready` equals `m_ready`.
- R9: Under random back-pressure on every port, each port receives the inbound beat sequence in order, with no beat dropped or duplicated.
- R10: While `s_valid` is low, every `m_valid` bit is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| s_valid | input | 1 | Inbound beat valid |
| s_ready | output | 1 | Inbound ready, the AND of all outbound readies |
| s_data | input | IN_DATA_W | Inbound data |
| s_user | input | IN_USER_W | Inbound user sideband |
| s_last | input | 1 | Inbound end-of-packet flag |
| m_valid | output | NUM_PORTS | Outbound valid, one bit per port |
| m_ready | input | NUM_PORTS | Outbound ready, one bit per port |
| m_data | output | NUM_PORTS*OUT_DATA_W | Packed outbound data, port 0 in the lowest slice |
| m_user | output | NUM_PORTS*OUT_USER_W | Packed outbound user, port 0 in the lowest slice |
| m_last | output | NUM_PORTS | End-of-packet flag, one bit per port |

## Verification
Every output is a pure combinational function of the present inputs, so each result is due in the same cycle as its stimulus, with zero register delay. The bench drives inputs on the falling clock edge and samples outputs one nanosecond later, after they have settled and well before the next rising edge. In the random back-pressure run, the handshakes are recorded at that same sample point and compared per port against a sequence number that the bench keeps itself.

// File: rtl/bcast_pkg.sv
package bcast_pkg;
    localparam int unsigned MAX_PORTS = 16;
    localparam int unsigned FIELD_W   = 8;
    localparam int unsigned PACK_W    = MAX_PORTS * FIELD_W;

    // Extract the 8-bit low-index field of a given port from a packed list.
    function automatic int unsigned field_at(input logic [PACK_W-1:0] vec, input int unsigned idx);
        return int'(vec[idx*FIELD_W +: FIELD_W]);
    endfunction
endpackage

// File: rtl/bcast_ready_combine.sv
module bcast_ready_combine #(
    parameter int unsigned NUM_PORTS = 3
) (
    input  logic [NUM_PORTS-1:0] m_ready,
    output logic                 all_ready,
    output logic [NUM_PORTS-1:0] others_ready
);
    assign all_ready = &m_ready;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_other
        localparam logic [NUM_PORTS-1:0] SELF_MASK = NUM_PORTS'(1) << p;
        // Force own bit high so the AND covers only the siblings (empty -> 1).
        assign others_ready[p] = &(m_ready | SELF_MASK);
    end
endmodule

// File: rtl/bcast_valid_gate.sv
module bcast_valid_gate #(
    parameter int unsigned NUM_PORTS = 3
) (
    input  logic                 s_valid,
    input  logic [NUM_PORTS-1:0] others_ready,
    output logic [NUM_PORTS-1:0] m_valid
);
    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            m_valid[p] = s_valid & others_ready[p];
        end
    end
endmodule

// File: rtl/bcast_slice_map.sv
module bcast_slice_map #(
    parameter int unsigned NUM_PORTS = 3,
    parameter int unsigned IN_W      = 32,
    parameter int unsigned OUT_W     = 24,
    parameter logic [NUM_PORTS*bcast_pkg::FIELD_W-1:0] LSB_PACK = '0
) (
    input  logic [IN_W-1:0]           in_bus,
    output logic [NUM_PORTS*OUT_W-1:0] out_bus
);
    localparam logic [bcast_pkg::PACK_W-1:0] LSB_WIDE = bcast_pkg::PACK_W'(LSB_PACK);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam int unsigned LO = bcast_pkg::field_at(LSB_WIDE, p);

        // R5 / R6: window must fit inside the inbound bus
        initial begin
            p_window_fits_r5: assert (LO + OUT_W <= IN_W)
                else $error("slice window of port %0d exceeds inbound width", p);
        end

        if (LO + OUT_W <= IN_W) begin : g_ok
            assign out_bus[p*OUT_W +: OUT_W] = in_bus[LO +: OUT_W];
        end else begin : g_bad
            assign out_bus[p*OUT_W +: OUT_W] = '0;
        end
    end
endmodule

// File: rtl/stream_fanout.sv
module stream_fanout #(
    parameter int unsigned NUM_PORTS  = 3,
    parameter int unsigned IN_DATA_W  = 32,
    parameter int unsigned OUT_DATA_W = 24,
    parameter int unsigned IN_USER_W  = 8,
    parameter int unsigned OUT_USER_W = 4,
    parameter logic [NUM_PORTS*8-1:0] DATA_LSB_PACK = {8'd4, 8'd8, 8'd0},
    parameter logic [NUM_PORTS*8-1:0] USER_LSB_PACK = {8'd2, 8'd4, 8'd0}
) (
    input  logic                             s_valid,
    output logic                             s_ready,
    input  logic [IN_DATA_W-1:0]             s_data,
    input  logic [IN_USER_W-1:0]             s_user,
    input  logic                             s_last,
    output logic [NUM_PORTS-1:0]             m_valid,
    input  logic [NUM_PORTS-1:0]             m_ready,
    output logic [NUM_PORTS*OUT_DATA_W-1:0]  m_data,
    output logic [NUM_PORTS*OUT_USER_W-1:0]  m_user,
    output logic [NUM_PORTS-1:0]             m_last
);
    logic [NUM_PORTS-1:0] others_ready;

    initial begin
        p_port_count_r8: assert (NUM_PORTS >= 1 && NUM_PORTS <= bcast_pkg::MAX_PORTS)
            else $error("port count out of range");
    end

    bcast_ready_combine #(.NUM_PORTS(NUM_PORTS)) ready_i (
        .m_ready      (m_ready),
        .all_ready    (s_ready),
        .others_ready (others_ready)
    );

    bcast_valid_gate #(.NUM_PORTS(NUM_PORTS)) gate_i (
        .s_valid      (s_valid),
        .others_ready (others_ready),
        .m_valid      (m_valid)
    );

    bcast_slice_map #(
        .NUM_PORTS (NUM_PORTS), .IN_W (IN_DATA_W), .OUT_W (OUT_DATA_W), .LSB_PACK (DATA_LSB_PACK)
    ) data_map_i (
        .in_bus  (s_data),
        .out_bus (m_data)
    );

    bcast_slice_map #(
        .NUM_PORTS (NUM_PORTS), .IN_W (IN_USER_W), .OUT_W (OUT_USER_W), .LSB_PACK (USER_LSB_PACK)
    ) user_map_i (
        .in_bus  (s_user),
        .out_bus (m_user)
    );

    // R7: end-of-packet flag reaches every slice
    assign m_last = {NUM_PORTS{s_last}};

    // Cross-checks between the ready combiner and the valid gate
    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            p_no_partial_beat_r3: assert (!(m_valid[p] && m_ready[p]) || (s_valid && s_ready))
                else $error("port %0d handshake without inbound transfer", p);
        end
        p_transfer_all_valid_r2: assert (!(s_valid && s_ready) || (&m_valid))
            else $error("inbound transfer while some port invalid");
        p_idle_quiet_r10: assert (s_valid || (m_valid == '0))
            else $error("outbound valid without inbound valid");
        if (NUM_PORTS > 1) begin
            p_lone_stall_r2: assert (!(s_valid && $countones(~m_ready) == 1) || (m_valid == ~m_ready))
                else $error("single stalled port not isolated");
        end
    end
endmodule

// File: tb/stream_fanout_tb_top.sv
module stream_fanout_tb_top;
    localparam int NP = 3;
    localparam int DW = 24;
    localparam int UW = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic             s_valid, s_ready, s_last;
    logic [31:0]      s_data;
    logic [7:0]       s_user;
    logic [NP-1:0]    m_valid, m_ready, m_last;
    logic [NP*DW-1:0] m_data;
    logic [NP*UW-1:0] m_user;

    stream_fanout dut_i (
        .s_valid (s_valid), .s_ready (s_ready), .s_data (s_data), .s_user (s_user),
        .s_last (s_last), .m_valid (m_valid), .m_ready (m_ready), .m_data (m_data),
        .m_user (m_user), .m_last (m_last)
    );

    // Single-port instance for R8
    logic        o_valid, o_ready, o_mvalid, o_mready, o_last, o_mlast;
    logic [31:0] o_data, o_mdata;
    logic [7:0]  o_user, o_muser;

    stream_fanout #(
        .NUM_PORTS (1), .IN_DATA_W (32), .OUT_DATA_W (32), .IN_USER_W (8), .OUT_USER_W (8),
        .DATA_LSB_PACK (8'd0), .USER_LSB_PACK (8'd0)
    ) one_i (
        .s_valid (o_valid), .s_ready (o_ready), .s_data (o_data), .s_user (o_user),
        .s_last (o_last), .m_valid (o_mvalid), .m_ready (o_mready), .m_data (o_mdata),
        .m_user (o_muser), .m_last (o_mlast)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [NP-1:0] rdy);
        @(negedge clk);
        s_valid = v;
        m_ready = rdy;
        #1;
    endtask

    function automatic logic [31:0] pay(input int k);
        return (32'(k) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    task automatic t_idle();
        drive(1'b0, 3'b111);
        chk("R10 idle valid", 128'(m_valid), 128'(3'b000));
        chk("R1 idle ready", 128'(s_ready), 128'(1'b1));
        drive(1'b0, 3'b010);
        chk("R10 idle valid partial ready", 128'(m_valid), 128'(3'b000));
    endtask

    task automatic t_all_ready();
        drive(1'b1, 3'b111);
        chk("R2 all ready valid", 128'(m_valid), 128'(3'b111));
        chk("R1 all ready", 128'(s_ready), 128'(1'b1));
    endtask

    task automatic t_stalls();
        drive(1'b1, 3'b101);
        chk("R1 port1 stalled", 128'(s_ready), 128'(1'b0));
        chk("R2 port1 stalled", 128'(m_valid), 128'(3'b010));
        drive(1'b1, 3'b011);
        chk("R2 port2 stalled", 128'(m_valid), 128'(3'b100));
        drive(1'b1, 3'b100);
        chk("R2 two stalled", 128'(m_valid), 128'(3'b000));
        chk("R1 two stalled", 128'(s_ready), 128'(1'b0));
        drive(1'b1, 3'b000);
        chk("R2 none ready", 128'(m_valid), 128'(3'b000));
    endtask

    task automatic t_remap();
        s_data = 32'h89AB_CDEF;
        s_user = 8'hC6;
        drive(1'b1, 3'b111);
        chk("R5 port0 data", 128'(m_data[0 +: DW]), 128'(24'hABCDEF));
        chk("R5 port1 data", 128'(m_data[DW +: DW]), 128'(24'h89ABCD));
        chk("R5 port2 data", 128'(m_data[2*DW +: DW]), 128'(24'h9ABCDE));
        chk("R4 packed data", 128'(m_data), 128'({24'h9ABCDE, 24'h89ABCD, 24'hABCDEF}));
        chk("R6 packed user", 128'(m_user), 128'({4'h1, 4'hC, 4'h6}));
    endtask

    task automatic t_last();
        s_last = 1'b1;
        drive(1'b1, 3'b111);
        chk("R7 last high", 128'(m_last), 128'(3'b111));
        s_last = 1'b0;
        drive(1'b1, 3'b111);
        chk("R7 last low", 128'(m_last), 128'(3'b000));
    endtask

    task automatic t_single();
        @(negedge clk);
        o_valid = 1'b1; o_mready = 1'b0; o_data = 32'hDEAD_BEEF; o_user = 8'h5C; o_last = 1'b1;
        #1;
        chk("R8 valid while not ready", 128'(o_mvalid), 128'(1'b1));
        chk("R8 ready follows", 128'(o_ready), 128'(1'b0));
        chk("R8 data pass", 128'({o_mdata, o_muser, o_mlast}), 128'({32'hDEAD_BEEF, 8'h5C, 1'b1}));
        @(negedge clk);
        o_valid = 1'b0; o_mready = 1'b1;
        #1;
        chk("R8 idle", 128'({o_mvalid, o_ready}), 128'(2'b01));
    endtask

    task automatic t_random();
        int sent = 0;
        int got[NP] = '{default: 0};
        int bad = 0;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            s_valid = ($urandom_range(0, 3) != 0);
            m_ready = NP'($urandom);
            s_data  = pay(sent);
            s_user  = 8'(sent);
            s_last  = (sent % 4 == 3);
            #1;
            for (int p = 0; p < NP; p++) begin
                if (m_valid[p] && m_ready[p]) begin
                    if (!(s_valid && s_ready)) bad++;          // R3
                    if (m_data[p*DW +: DW] !== pay(got[p])[p == 0 ? 0 : (p == 1 ? 8 : 4) +: DW]) bad++;
                    if (m_last[p] !== (got[p] % 4 == 3)) bad++;
                    got[p]++;
                end
            end
            if (s_valid && s_ready) sent++;
        end
        chk("R9 beats sent nonzero", 128'(sent > 100), 128'(1));
        for (int p = 0; p < NP; p++) chk("R9 per-port beat count", 128'(got[p]), 128'(sent));
        chk("R9 R3 ordered payload and lockstep", 128'(bad), 128'(0));
    endtask

    initial begin
        s_valid = 0; s_data = '0; s_user = '0; s_last = 0; m_ready = '0;
        o_valid = 0; o_data = '0; o_user = '0; o_last = 0; o_mready = 0;
        t_idle();
        t_all_ready();
        t_stalls();
        t_remap();
        t_last();
        t_single();
        t_random();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule